// File: doc/BRIEF.md
# Per-Byte Parity Checker and Generator

This block holds the parity logic for one 36-bit port that carries four 9-bit bytes. The top bit of each byte is its parity bit. In its passive role it watches the inbound bus on every clock and drives an active-low error flag whenever any byte has the wrong parity. The flag only reports; it never holds back a write.

The same four parity trees also serve outbound mailbox reads. When a mailbox read with generation is selected, the trees are switched to the outgoing read data. The block then rewrites the four parity bits so that each byte carries the selected parity, and it holds the error flag inactive for that cycle.

One input picks odd or even parity for both roles. Both outputs are registered and follow their inputs by one clock.

Top module: `byte_parity_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `perr_n` becomes 1 and `rd_out` becomes all zeros.
- R2: The bus is split into bytes at bits 8:0, 17:9, 26:18 and 35:27, and bits 8, 17, 26 and 35 are the parity bits. In a cycle that is not a generate read (R5), `perr_n` is 0 one clock later if any byte of `bus_in` fails parity.
- R3: With `odd_sel` = 1, a byte passes when its nine bits hold an odd number of ones. With `odd_sel` = 0, it passes when they hold an even number. The same sense applies to generation.
- R4: Checking does not depend on `cs_n`, `en`, `wr_sel` or `mbox_sel`. When every byte of `bus_in` passes and the cycle is not a generate read, `perr_n` is 1 one clock later.
- R5: A generate read is a cycle with `cs_n`=0, `en`=1, `wr_sel`=0 (read), `mbox_sel`=1 and `gen_en`=1. One clock after a generate read, bits 8, 17, 26 and 35 of `rd_out` are recomputed from `rd_data` so that every byte has the selected parity.
- R6: The 32 data bits of `rd_out` always equal the data bits of `rd_data` one clock earlier.
- R7: In any cycle that is not a generate read, `rd_out` equals `rd_data` one clock later, parity bits included. Raising `gen_en` on its own has no effect.
- R8: One clock after a generate read, `perr_n` is 1, whatever the value of `bus_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_in | input | 36 | Inbound bus being checked |
| rd_data | input | 36 | Outgoing read data, before parity replacement |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even |
| gen_en | input | 1 | Enables parity generation on mailbox reads |
| cs_n | input | 1 | Port select, active low |
| en | input | 1 | Transfer enable, active high |
| wr_sel | input | 1 | 1 for a write, 0 for a read |
| mbox_sel | input | 1 | Selects the mailbox path |
| rd_out | output | 36 | Registered outgoing data |
| perr_n | output | 1 | Registered parity error flag, active low |

## Verification
If a tree were wired to the wrong byte, or took the wrong sense of `odd_sel`, `perr_n` would give the wrong answer one clock after the first bus value that breaks a single byte. For that reason every byte is corrupted on its own, under both parity senses. If the source mux were held in the wrong position, a generate read would output bad parity bits or would let a bad `bus_in` pull the flag low, again within one clock. A decode of the generate read that ignores any one of its five terms would rewrite parity bits that should pass through untouched. The bench therefore clears each term in turn.

// File: rtl/parity_pkg.sv
package parity_pkg;
  localparam int LANES_DEF = 4;
  localparam int DBITS_DEF = 8;

  typedef enum logic {
    SRC_INBOUND  = 1'b0,
    SRC_OUTBOUND = 1'b1
  } tree_src_e;
endpackage

// File: rtl/parity_lane.sv
module parity_lane #(
  parameter int DBITS = 8
) (
  input  logic [DBITS:0] lane,
  input  logic           odd_sel,
  output logic           fill_bit,
  output logic           fault
);
  // A single xor tree over the data bits gives both the bit to insert
  // and, with the received parity bit folded in, the check result.
  assign fill_bit = (^lane[DBITS-1:0]) ^ odd_sel;
  assign fault    = fill_bit ^ lane[DBITS];
endmodule

// File: rtl/byte_parity_unit.sv
module byte_parity_unit
  import parity_pkg::*;
#(
  parameter int LANES = LANES_DEF,
  parameter int DBITS = DBITS_DEF,
  localparam int LW = DBITS + 1,
  localparam int W  = LANES * LW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] bus_in,
  input  logic [W-1:0] rd_data,
  input  logic         odd_sel,
  input  logic         gen_en,
  input  logic         cs_n,
  input  logic         en,
  input  logic         wr_sel,
  input  logic         mbox_sel,
  output logic [W-1:0] rd_out,
  output logic         perr_n
);
  logic           gen_rd;
  tree_src_e      src;
  logic [W-1:0]   tree_in;
  logic [W-1:0]   out_nxt;
  logic [LANES-1:0] fill;
  logic [LANES-1:0] fault;

  assign gen_rd  = !cs_n && en && !wr_sel && mbox_sel && gen_en;
  assign src     = gen_rd ? SRC_OUTBOUND : SRC_INBOUND;
  assign tree_in = (src == SRC_OUTBOUND) ? rd_data : bus_in;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    parity_lane #(.DBITS(DBITS)) u_lane (
      .lane     (tree_in[l*LW +: LW]),
      .odd_sel  (odd_sel),
      .fill_bit (fill[l]),
      .fault    (fault[l])
    );
    assign out_nxt[l*LW +: DBITS] = rd_data[l*LW +: DBITS];
    assign out_nxt[l*LW + DBITS]  = (src == SRC_OUTBOUND) ? fill[l]
                                                          : rd_data[l*LW + DBITS];

    // R2: a failing inbound byte pulls the flag low next clock
    assert_lane_fault_R2: assert property (@(posedge clk) disable iff (rst)
      (!(!cs_n && en && !wr_sel && mbox_sel && gen_en) &&
       ((^bus_in[l*LW +: LW]) != odd_sel)) |=> !perr_n);

    // R5: generated bytes carry the selected parity
    assert_gen_parity_R5: assert property (@(posedge clk) disable iff (rst)
      (!cs_n && en && !wr_sel && mbox_sel && gen_en) |=>
      ((^rd_out[l*LW +: LW]) == $past(odd_sel)));

    // R6: data bits always pass through
    assert_data_pass_R6: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (rd_out[l*LW +: DBITS] == $past(rd_data[l*LW +: DBITS])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      perr_n <= 1'b1;
      rd_out <= '0;
    end else begin
      perr_n <= (src == SRC_OUTBOUND) || !(|fault);
      rd_out <= out_nxt;
    end
  end

  // R7: outside a generate read the data is copied unchanged
  assert_copy_R7: assert property (@(posedge clk) disable iff (rst)
    (!rst && !(!cs_n && en && !wr_sel && mbox_sel && gen_en)) |=>
    (rd_out == $past(rd_data)));

  // R8: a generate read holds the flag inactive
  assert_forced_high_R8: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && en && !wr_sel && mbox_sel && gen_en) |=> perr_n);
endmodule

// File: tb/byte_parity_unit_bench.sv
module byte_parity_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [35:0] bus_in = '0;
  logic [35:0] rd_data = '0;
  logic        odd_sel = 1'b0;
  logic        gen_en = 1'b0;
  logic        cs_n = 1'b1;
  logic        en = 1'b0;
  logic        wr_sel = 1'b0;
  logic        mbox_sel = 1'b0;
  logic [35:0] rd_out;
  logic        perr_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  byte_parity_unit u_byte_parity_unit (
    .clk(clk), .rst(rst), .bus_in(bus_in), .rd_data(rd_data),
    .odd_sel(odd_sel), .gen_en(gen_en), .cs_n(cs_n), .en(en),
    .wr_sel(wr_sel), .mbox_sel(mbox_sel), .rd_out(rd_out), .perr_n(perr_n)
  );

  function automatic logic [35:0] fix_par(input logic [35:0] d, input logic odd);
    logic [35:0] r = d;
    for (int k = 0; k < 4; k++) begin
      int c = $countones(d[k*9 +: 8]);
      r[k*9+8] = odd ? (c % 2 == 0) : (c % 2 == 1);
    end
    return r;
  endfunction

  function automatic logic any_fail(input logic [35:0] d, input logic odd);
    logic f = 1'b0;
    for (int k = 0; k < 4; k++)
      if ((($countones(d[k*9 +: 9]) % 2) == 1) != odd) f = 1'b1;
    return f;
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [35:0] b, input logic [35:0] r, input logic odd,
                      input logic g, input logic c, input logic e, input logic w,
                      input logic m);
    @(negedge clk);
    bus_in = b; rd_data = r; odd_sel = odd; gen_en = g;
    cs_n = c; en = e; wr_sel = w; mbox_sel = m;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1; bus_in = 36'h0_0000_0001; rd_data = 36'hF_FFFF_FFFF;
    @(posedge clk); #1;
    chk("R1 perr_n", {35'd0, perr_n}, 36'd1);
    chk("R1 rd_out", rd_out, 36'd0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_good();
    logic [35:0] pats [4] = '{36'h0_0000_0000, 36'h1_2345_6789, 36'hA_5A5A_5A5A, 36'hF_FFFF_FFFF};
    for (int o = 0; o < 2; o++)
      foreach (pats[i]) begin
        logic [35:0] b = fix_par(pats[i], o[0]);
        step(b, 36'd0, o[0], 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R4 good bus", {35'd0, perr_n}, 36'd1);
      end
  endtask

  task automatic t_bad_lanes();
    for (int o = 0; o < 2; o++)
      for (int k = 0; k < 4; k++) begin
        logic [35:0] b = fix_par(36'h3_C3C3_C3C3, o[0]);
        b[k*9+3] = ~b[k*9+3];
        step(b, 36'd0, o[0], 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R2 data bit flip", {35'd0, perr_n}, 36'd0);
        b = fix_par(36'h3_C3C3_C3C3, o[0]);
        b[k*9+8] = ~b[k*9+8];
        step(b, 36'd0, o[0], 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R2 parity bit flip", {35'd0, perr_n}, 36'd0);
      end
  endtask

  task automatic t_sense();
    step(36'd0, 36'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R3 zeros even", {35'd0, perr_n}, 36'd1);
    step(36'd0, 36'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R3 zeros odd", {35'd0, perr_n}, 36'd0);
    step(36'h8_0402_0100, 36'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R3 one per byte odd", {35'd0, perr_n}, 36'd1);
  endtask

  task automatic t_passive();
    logic [35:0] b = fix_par(36'h0_1111_1111, 1'b0) ^ 36'h0_0000_0200;
    step(b, 36'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R4 deselected still checks", {35'd0, perr_n}, {35'd0, ~any_fail(b, 1'b0)});
    step(fix_par(b, 1'b0), 36'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R4 deselected good", {35'd0, perr_n}, 36'd1);
  endtask

  task automatic t_gen();
    logic [35:0] src [3] = '{36'h0_0000_0000, 36'hF_1234_5678, 36'h5_DEAD_BEEF};
    for (int o = 0; o < 2; o++)
      foreach (src[i]) begin
        step(36'd0, src[i], o[0], 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R5 generated parity", rd_out, fix_par(src[i], o[0]));
        chk("R6 data bits", rd_out & ~36'h8_0402_0100, src[i] & ~36'h8_0402_0100);
      end
  endtask

  task automatic t_force();
    logic [35:0] b = 36'h0_0000_0001;
    step(b, 36'h1_0000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R8 forced high", {35'd0, perr_n}, 36'd1);
    step(b, 36'h1_0000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R2 after release", {35'd0, perr_n}, 36'd0);
  endtask

  task automatic t_no_gen();
    logic [35:0] r = 36'h8_0000_0001;
    step(36'd0, r, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R7 gen_en low", rd_out, r);
    step(36'd0, r, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R7 cs_n high", rd_out, r);
    step(36'd0, r, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7 en low", rd_out, r);
    step(36'd0, r, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R7 write", rd_out, r);
    step(36'd0, r, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7 fifo read", rd_out, r);
    chk("R6 copy keeps data", rd_out & 36'h0_0000_00FF, 36'h0_0000_0001);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_good();
    t_bad_lanes();
    t_sense();
    t_passive();
    t_gen();
    t_force();
    t_no_gen();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule